// File: doc/BRIEF.md
# Descriptor Ring Tail-Pointer Controller

This block steps one DMA channel through a circular ring of fixed-size descriptors held in memory. Software sets the ring's start address, its length in entries, and a tail pointer. The tail pointer is the address just past the last descriptor that software has prepared. The block keeps a current index. It owns every descriptor from the current index up to, but not including, the tail. It requests each owned descriptor through a valid/ready fetch port and moves on when a completion pulse returns. When it passes the last entry it wraps to the start of the ring. It goes idle in a suspended state once the current index reaches the tail.

The same block serves a transmit ring or a receive ring, because both directions use the same mechanism. Software restarts a suspended channel by writing a tail that lies ahead of the current entry. A run bit gates all new requests. Ring geometry may only be changed while the channel is stopped, and changing it rewinds the channel to the ring start.

Top module: `desc_ring_ctrl`

## Requirements
- R1: After reset the channel is stopped, `curDescAddr` is 0, `fetchValid` is 0 and `suspended` is 0.
- R2: `fetchAddr` equals the ring start plus 16 times the current index. Once `fetchValid` is raised, it and `fetchAddr` hold steady until `fetchReady` is seen high.
- R3: A `descDone` pulse after an accepted request moves `curDescAddr` forward by 16 bytes. Otherwise the pointer changes only on a geometry write.
- R4: After the entry at index length-1, the next entry is the ring start.
- R5: When the current index equals the tail index while running, `suspended` is 1 in that same cycle and no request is issued.
- R6: A tail write that is ahead of the current entry resumes fetching. A tail write equal to the current entry leaves the channel suspended.
- R7: The tail index is taken modulo the ring length. A tail below the current entry counts as ahead, past the wrap, and a tail equal to start + 16 × length maps to index 0.
- R8: With the run bit clear (`regSel`=3, bit 0 = 0), no new request starts and `suspended` is 0. Setting the bit resumes owned work.
- R9: A write of the start address (`regSel`=0) or the length (`regSel`=1) while stopped sets the current and tail indices to 0. The same writes while running are ignored. `regSel`=2 writes the tail address.
- R10: Only one descriptor is outstanding. After a request is accepted, `fetchValid` stays low until `descDone`.
- R11: A `descDone` and a tail write in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | 0 start address, 1 length, 2 tail address, 3 control (bit 0 run) |
| regWrData | input | ADDR_W | Write data |
| fetchValid | output | 1 | Descriptor fetch request |
| fetchReady | input | 1 | Fetch request accepted |
| fetchAddr | output | ADDR_W | Address of the requested descriptor |
| descDone | input | 1 | Single-cycle completion of the outstanding descriptor |
| curDescAddr | output | ADDR_W | Current descriptor address |
| suspended | output | 1 | Running with no owned descriptor |

## Verification
Two events can land in the same clock edge: the completion that advances the current index, and a software tail write that moves ownership. The bench's fetch responder issues a tail write in the very cycle it pulses `descDone`. That moves the tail two entries further while the pointer steps forward. The scoreboard then expects exactly the descriptors between the advanced pointer and the new tail, followed by a suspend at the new tail. If either update were lost, the run would show a missing or extra fetch, or a wrong final address.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_TAIL = 2'd2,
    SEL_CTRL = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } fetchState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;
    logic rewind;
    logic loadBase;
    logic loadLen;
    logic loadTail;
  } dpStrobe_t;

endpackage

// File: rtl/desc_ring_datapath.sv
module desc_ring_datapath
  import desc_ring_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 8,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [ADDR_W-1:0] wrData,
  output logic [ADDR_W-1:0] curAddr,
  output logic              hasWork
);
  localparam int SHIFT = $clog2(DESC_BYTES);

  logic [ADDR_W-1:0] baseAddr;
  logic [IDX_W-1:0]  ringLen;
  logic [IDX_W-1:0]  curIdx;
  logic [IDX_W-1:0]  tailIdx;

  logic [ADDR_W-1:0] tailOff;
  logic [ADDR_W-1:0] tailShift;
  logic [IDX_W:0]    tailRaw;
  logic [IDX_W:0]    tailMod;
  logic [IDX_W-1:0]  nextIdx;
  logic              unusedTailHi;

  // tail address -> ring index, folded once modulo the length
  always_comb begin
    tailOff   = wrData - baseAddr;
    tailShift = tailOff >> SHIFT;
    tailRaw   = tailShift[IDX_W:0];
    if (tailRaw >= {1'b0, ringLen}) tailMod = tailRaw - {1'b0, ringLen};
    else                            tailMod = tailRaw;
  end
  assign unusedTailHi = ^{tailShift[ADDR_W-1:IDX_W+1], tailOff[SHIFT-1:0], tailMod[IDX_W]};

  always_comb begin
    if (curIdx == ringLen - IDX_W'(1)) nextIdx = '0;
    else                               nextIdx = curIdx + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      ringLen  <= '0;
      curIdx   <= '0;
      tailIdx  <= '0;
    end else begin
      if (stb.loadBase) baseAddr <= wrData;
      if (stb.loadLen)  ringLen  <= wrData[IDX_W-1:0];
      if (stb.rewind) begin
        curIdx  <= '0;
        tailIdx <= '0;
      end else begin
        if (stb.advance)  curIdx  <= nextIdx;
        if (stb.loadTail) tailIdx <= tailMod[IDX_W-1:0];
      end
    end
  end

  assign curAddr = baseAddr + ({{(ADDR_W-IDX_W){1'b0}}, curIdx} << SHIFT);
  assign hasWork = (curIdx != tailIdx);

endmodule

// File: rtl/desc_ring_ctl_fsm.sv
module desc_ring_ctl_fsm
  import desc_ring_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      regWrEn,
  input  logic [1:0] regSel,
  input  logic      runIn,
  input  logic      fetchReady,
  input  logic      descDone,
  input  logic      hasWork,
  output dpStrobe_t stb,
  output logic      fetchValid,
  output logic      suspended
);
  fetchState_e state, stateNext;
  logic        runBit;
  regSel_e     sel;

  assign sel = regSel_e'(regSel);

  always_comb begin
    stb          = '0;
    stb.loadBase = regWrEn && (sel == SEL_BASE) && !runBit;
    stb.loadLen  = regWrEn && (sel == SEL_LEN)  && !runBit;
    stb.rewind   = stb.loadBase || stb.loadLen;
    stb.loadTail = regWrEn && (sel == SEL_TAIL);
    stb.advance  = (state == ST_WAIT) && descDone;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (runBit && hasWork) stateNext = ST_REQ;
      ST_REQ:  if (fetchReady)        stateNext = ST_WAIT;
      ST_WAIT: if (descDone)          stateNext = ST_IDLE;
      default:                        stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      runBit <= 1'b0;
    end else begin
      state <= stateNext;
      if (regWrEn && (sel == SEL_CTRL)) runBit <= runIn;
    end
  end

  assign fetchValid = (state == ST_REQ);
  assign suspended  = runBit && (state == ST_IDLE) && !hasWork;

endmodule

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl
  import desc_ring_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 8,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWrData,
  output logic              fetchValid,
  input  logic              fetchReady,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic              descDone,
  output logic [ADDR_W-1:0] curDescAddr,
  output logic              suspended
);
  dpStrobe_t stb;
  logic      hasWork;

  desc_ring_ctl_fsm u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .runIn      (regWrData[0]),
    .fetchReady (fetchReady),
    .descDone   (descDone),
    .hasWork    (hasWork),
    .stb        (stb),
    .fetchValid (fetchValid),
    .suspended  (suspended)
  );

  desc_ring_datapath #(
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W),
    .DESC_BYTES (DESC_BYTES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (regWrData),
    .curAddr (curDescAddr),
    .hasWork (hasWork)
  );

  assign fetchAddr = curDescAddr;

endmodule

// File: rtl/desc_ring_ctrl_chk.sv
module desc_ring_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [1:0]        regSel,
  input logic              fetchValid,
  input logic              fetchReady,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              descDone,
  input logic [ADDR_W-1:0] curDescAddr,
  input logic              suspended
);
  // R2: request and its address held until accepted
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !fetchReady) |=> (fetchValid && $stable(fetchAddr)));

  // R10: one outstanding descriptor
  a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && fetchReady) |=> !fetchValid);

  // R5: no request while suspended
  a_r5_no_fetch_suspended: assert property (@(posedge clk) disable iff (!rstN)
    suspended |-> !fetchValid);

  // R3: pointer moves only on completion or geometry write
  a_r3_ptr_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!descDone && !(regWrEn && (regSel == 2'd0 || regSel == 2'd1)))
      |=> $stable(curDescAddr));

endmodule

bind desc_ring_ctrl desc_ring_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .regWrEn     (regWrEn),
  .regSel      (regSel),
  .fetchValid  (fetchValid),
  .fetchReady  (fetchReady),
  .fetchAddr   (fetchAddr),
  .descDone    (descDone),
  .curDescAddr (curDescAddr),
  .suspended   (suspended)
);

// File: tb/desc_ring_ctrl_tb.sv
`timescale 1ns/1ps
module desc_ring_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        drvWrEn = 1'b0;
  logic [1:0]  drvSel = 2'd0;
  logic [31:0] drvData = '0;
  logic        respWrEn = 1'b0;
  logic [31:0] respData = '0;
  logic        regWrEn;
  logic [1:0]  regSel;
  logic [31:0] regWrData;
  logic        fetchValid, fetchReady = 1'b0, descDone = 1'b0, suspended;
  logic [31:0] fetchAddr, curDescAddr;

  int total = 0, bad = 0;
  int doneCnt = 0, seenCnt = 0, target = 0;
  int respDelay = 0, doneLat = 0;
  logic        tailOnDone = 1'b0;
  logic [31:0] tailOnDoneVal = '0;
  logic [31:0] expQ[$];

  assign regWrEn   = drvWrEn | respWrEn;
  assign regSel    = respWrEn ? 2'd2 : drvSel;
  assign regWrData = respWrEn ? respData : drvData;

  always #2.5 clk = ~clk;

  desc_ring_ctrl u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .fetchValid(fetchValid), .fetchReady(fetchReady),
    .fetchAddr(fetchAddr), .descDone(descDone), .curDescAddr(curDescAddr),
    .suspended(suspended)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] data);
    @(negedge clk);
    drvWrEn = 1'b1; drvSel = sel; drvData = data;
    @(negedge clk);
    drvWrEn = 1'b0;
  endtask

  task automatic expect_fetch(logic [31:0] a);
    expQ.push_back(a);
    target++;
  endtask

  task automatic drain();
    wait (doneCnt == target);
    repeat (3) @(negedge clk);
    chk("scoreboard empty", 32'(expQ.size()), 32'd0);
  endtask

  // monitor / responder: pops expected addresses and answers the fetch port
  always begin
    @(negedge clk);
    if (fetchValid) begin
      logic [31:0] addrSeen;
      seenCnt++;
      addrSeen = fetchAddr;
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL R6 unexpected fetch actual=%h expected=none", fetchAddr);
      end else begin
        chk("R2 fetch address", fetchAddr, expQ.pop_front());
      end
      for (int i = 0; i < respDelay; i++) begin
        @(negedge clk);
        chk("R2 valid held", {31'd0, fetchValid}, 32'd1);
        chk("R2 address held", fetchAddr, addrSeen);
      end
      fetchReady = 1'b1;
      @(negedge clk);
      fetchReady = 1'b0;
      for (int i = 0; i < doneLat; i++) begin
        chk("R10 no second request", {31'd0, fetchValid}, 32'd0);
        @(negedge clk);
      end
      chk("R10 no second request", {31'd0, fetchValid}, 32'd0);
      descDone = 1'b1;
      if (tailOnDone) begin
        respWrEn = 1'b1; respData = tailOnDoneVal; tailOnDone = 1'b0;
      end
      @(negedge clk);
      descDone = 1'b0;
      respWrEn = 1'b0;
      doneCnt++;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pointer", curDescAddr, 32'd0);
    chk("R1 valid", {31'd0, fetchValid}, 32'd0);
    chk("R1 suspended", {31'd0, suspended}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 pointer after release", curDescAddr, 32'd0);

    // R9 geometry while stopped
    wr(2'd0, 32'h1000);
    chk("R9 rewind to base", curDescAddr, 32'h1000);
    wr(2'd1, 32'd4);
    wr(2'd2, 32'h1030);
    expect_fetch(32'h1000); expect_fetch(32'h1010); expect_fetch(32'h1020);
    wr(2'd3, 32'd1);
    drain();
    chk("R3 advance by 16", curDescAddr, 32'h1030);
    chk("R5 suspended at tail", {31'd0, suspended}, 32'd1);

    // R6 tail equal to current stays suspended
    s = seenCnt;
    wr(2'd2, 32'h1030);
    chk("R5 suspended same cycle", {31'd0, suspended}, 32'd1);
    repeat (8) @(negedge clk);
    chk("R6 equal tail no fetch", 32'(seenCnt), 32'(s));
    chk("R6 equal tail suspended", {31'd0, suspended}, 32'd1);

    // R4/R7 tail past wrap is ahead
    respDelay = 2; doneLat = 2;
    expect_fetch(32'h1030); expect_fetch(32'h1000);
    wr(2'd2, 32'h1010);
    drain();
    chk("R4 wrapped pointer", curDescAddr, 32'h1010);
    chk("R6 resumed then suspended", {31'd0, suspended}, 32'd1);

    // R7 tail at ring end maps to index 0
    respDelay = 0; doneLat = 0;
    expect_fetch(32'h1010); expect_fetch(32'h1020); expect_fetch(32'h1030);
    wr(2'd2, 32'h1040);
    drain();
    chk("R7 end tail wraps to base", curDescAddr, 32'h1000);

    // R9 geometry writes ignored while running
    wr(2'd0, 32'h2000);
    wr(2'd1, 32'd2);
    chk("R9 ignored while running", curDescAddr, 32'h1000);
    chk("R9 still suspended", {31'd0, suspended}, 32'd1);

    // R11 completion and tail write in the same cycle
    tailOnDone = 1'b1; tailOnDoneVal = 32'h1030;
    expect_fetch(32'h1000); expect_fetch(32'h1010); expect_fetch(32'h1020);
    wr(2'd2, 32'h1010);
    drain();
    chk("R11 both updates applied", curDescAddr, 32'h1030);
    chk("R11 suspended at new tail", {31'd0, suspended}, 32'd1);

    // R8 run bit gates requests
    wr(2'd3, 32'd0);
    chk("R8 stopped not suspended", {31'd0, suspended}, 32'd0);
    s = seenCnt;
    wr(2'd2, 32'h1010);
    repeat (10) @(negedge clk);
    chk("R8 no fetch while stopped", 32'(seenCnt), 32'(s));
    chk("R8 valid low while stopped", {31'd0, fetchValid}, 32'd0);
    expect_fetch(32'h1030); expect_fetch(32'h1000);
    wr(2'd3, 32'd1);
    drain();
    chk("R8 resumed on run", curDescAddr, 32'h1010);

    // R9 re-geometry while stopped, R4 two-entry wrap
    wr(2'd3, 32'd0);
    wr(2'd0, 32'h2000);
    chk("R9 base reload", curDescAddr, 32'h2000);
    wr(2'd1, 32'd2);
    wr(2'd2, 32'h2010);
    expect_fetch(32'h2000);
    wr(2'd3, 32'd1);
    drain();
    chk("R3 next entry", curDescAddr, 32'h2010);
    expect_fetch(32'h2010);
    wr(2'd2, 32'h2020);
    drain();
    chk("R4 two-entry wrap", curDescAddr, 32'h2000);
    chk("R5 suspended after wrap", {31'd0, suspended}, 32'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule